// File: doc/BRIEF.md
# Character Display Command Decoder

This block sits between a host bus and the rest of a character display controller. Each host access carries two register-select bits, a read/write bit and a data byte. The block sorts the access into one of four paths: command, status, display/character RAM data, or contrast data. Commands are decoded by the highest set bit of the byte. The block holds the display configuration, the contrast value and the shared RAM address counter. It drives a simple write port and a read address toward RAM arrays that live outside the block.

Each accepted command or data access raises a busy flag. The flag stays up for a fixed number of internal-oscillator ticks, which are supplied as a one-cycle enable. Because the delay is counted in ticks, the execution time scales with the oscillator frequency. While busy, every access except the status read is dropped without being queued. A status read returns the busy flag and the address counter.

Top module: `charlcd_cmd_unit`

## Requirements
- R1: After reset, busy is 0, the interface setting is 8-bit, one line, 5x7 font, display, cursor and blink are off, the entry mode is increment without shift, contrast is 0 and the address counter is 0 with the display RAM selected.
- R2: The register-select value `bus_rs` picks the path. 2'b10 with write is a command and 2'b10 with read is a status read. 2'b11 is a RAM data access. 2'b00 is a contrast access. 2'b01 is dropped and starts no busy period.
- R3: A command byte is decoded by its highest set bit. Bit 7 sets the display address, bit 6 the character address, bit 5 the function, bit 4 a shift, bit 3 display control, bit 2 entry mode, bit 1 home and bit 0 clear. A byte of 0x00 is dropped.
- R4: In function set, bit 4 selects the 8-bit interface (1) or 4-bit (0), bit 3 selects two lines (1) or one (0), and bit 2 selects the 5x10 font (1) or 5x7 (0).
- R5: In display control, bit 2 turns the display on, bit 1 the cursor and bit 0 the blink. In entry mode, bit 1 selects increment (1) or decrement (0) and bit 0 enables display shift.
- R6: An accepted access other than a status read raises `busy` at the next clock edge. Clear and home hold it for LONG_TICKS (410) oscillator ticks and all other accesses for SHORT_TICKS (10). `busy` falls at the edge that takes the last tick, and a tick in the accepting cycle is not counted.
- R7: A status read returns `busy` in bit 7 and the address counter in bits 6:0 of `bus_rdata`, one cycle later. It is served even while busy and starts no busy period.
- R8: Any access other than a status read that arrives while `busy` is 1 is dropped. Configuration, contrast, address counter and RAM are left unchanged.
- R9: A display-address command loads bits 6:0 into the address counter and selects display RAM. A character-address command loads bits 5:0 and selects character RAM.
- R10: A data write pulses `ram_we` for one cycle, with the current counter and RAM select on the write port. A data read returns the byte at the current address on `bus_rdata`. Both then step the counter by +1 or -1 as the entry mode selects, wrapping modulo 128.
- R11: A contrast write stores the byte in `contrast`, and a contrast read returns it on `bus_rdata`.
- R12: Clear and home zero the address counter, select display RAM and pulse `clear_stb` or `home_stb`. A shift command pulses `shift_stb` and latches bit 3 into `shift_disp` and bit 2 into `shift_right`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | One-cycle host access strobe |
| bus_rs | input | 2 | Register select |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| osc_tick | input | 1 | Internal oscillator tick enable |
| busy | output | 1 | Execution in progress |
| entry_inc | output | 1 | Address step direction, 1 = increment |
| entry_shift | output | 1 | Display shift on data access |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| bus8 | output | 1 | 8-bit interface selected |
| two_line | output | 1 | Two-line mode |
| font_tall | output | 1 | 5x10 font |
| contrast | output | 8 | Contrast value |
| ram_addr | output | AW | Read address (address counter) |
| ram_cg | output | 1 | Read select, 1 = character RAM |
| ram_rdata | input | 8 | Byte at ram_addr/ram_cg |
| ram_we | output | 1 | Write pulse |
| ram_waddr | output | AW | Write address |
| ram_wcg | output | 1 | Write select, 1 = character RAM |
| ram_wdata | output | 8 | Write byte |
| clear_stb | output | 1 | Clear command pulse |
| home_stb | output | 1 | Home command pulse |
| shift_stb | output | 1 | Shift command pulse |
| shift_disp | output | 1 | Last shift moved the display (else cursor) |
| shift_right | output | 1 | Last shift went right |

## Verification
The hardest case to reach from the ports is the exact edge where `busy` falls, since it depends on counting oscillator ticks and not clock cycles. The bench feeds ticks one at a time and checks that `busy` is still high after one tick fewer than the count, then low after the last one, for both the short and the long delay. Dropped accesses are driven right after an accepted one, inside the busy window. Their absence is then shown through status reads, the configuration outputs and contrast reads once the window closes. Address wrap is reached by loading the counter at its end points and stepping in each direction.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT, OP_FUNC,
    OP_CGADR, OP_DDADR, OP_STATUS, OP_DWR, OP_DRD, OP_KWR, OP_KRD
  } op_e;

  localparam logic [1:0] RS_CTR  = 2'b00;
  localparam logic [1:0] RS_CMD  = 2'b10;
  localparam logic [1:0] RS_DATA = 2'b11;
endpackage

// File: rtl/charlcd_decode.sv
module charlcd_decode
  import charlcd_pkg::*;
(
  input  logic [1:0] rs,
  input  logic       rw,
  input  logic [7:0] d,
  output op_e        op
);
  always_comb begin
    op = OP_NONE;
    case (rs)
      RS_CMD: begin
        if (rw)        op = OP_STATUS;
        else if (d[7]) op = OP_DDADR;
        else if (d[6]) op = OP_CGADR;
        else if (d[5]) op = OP_FUNC;
        else if (d[4]) op = OP_SHIFT;
        else if (d[3]) op = OP_DISP;
        else if (d[2]) op = OP_ENTRY;
        else if (d[1]) op = OP_HOME;
        else if (d[0]) op = OP_CLEAR;
      end
      RS_DATA: op = rw ? OP_DRD : OP_DWR;
      RS_CTR:  op = rw ? OP_KRD : OP_KWR;
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/charlcd_busy_timer.sv
module charlcd_busy_timer #(
  parameter int LONG_TICKS  = 410,
  parameter int SHORT_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  input  logic tick,
  output logic busy
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_TICKS);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= long_sel ? LONG_C : SHORT_C;
    end else if (busy && tick) begin
      if (cnt == ONE_C) busy <= 1'b0;
      cnt <= cnt - ONE_C;
    end
  end
endmodule

// File: rtl/charlcd_addr_ctr.sv
module charlcd_addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          load_cg,
  input  logic          step,
  input  logic          inc,
  output logic [AW-1:0] ac,
  output logic          cg_sel
);
  localparam logic [AW-1:0] ONE_A = AW'(1);

  always_ff @(posedge clk) begin
    if (rst || zero) begin
      ac     <= '0;
      cg_sel <= 1'b0;
    end else if (load) begin
      ac     <= load_val;
      cg_sel <= load_cg;
    end else if (step) begin
      ac <= inc ? ac + ONE_A : ac - ONE_A;
    end
  end
endmodule

// File: rtl/charlcd_cmd_unit.sv
module charlcd_cmd_unit
  import charlcd_pkg::*;
#(
  parameter int AW          = 7,
  parameter int LONG_TICKS  = 410,
  parameter int SHORT_TICKS = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [1:0]    bus_rs,
  input  logic          bus_rw,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          osc_tick,
  output logic          busy,
  output logic          entry_inc,
  output logic          entry_shift,
  output logic          disp_on,
  output logic          cursor_on,
  output logic          blink_on,
  output logic          bus8,
  output logic          two_line,
  output logic          font_tall,
  output logic [7:0]    contrast,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cg,
  input  logic [7:0]    ram_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic          ram_wcg,
  output logic [7:0]    ram_wdata,
  output logic          clear_stb,
  output logic          home_stb,
  output logic          shift_stb,
  output logic          shift_disp,
  output logic          shift_right
);
  localparam int DW = 8;

  op_e           op;
  logic          acc;
  logic [AW-1:0] ac;
  logic          cg_sel;
  logic [AW-1:0] load_val;

  charlcd_decode u_dec (.rs(bus_rs), .rw(bus_rw), .d(bus_wdata), .op(op));

  assign acc      = bus_valid && (op != OP_NONE) && (!busy || op == OP_STATUS);
  assign load_val = (op == OP_CGADR) ? {1'b0, bus_wdata[AW-2:0]} : bus_wdata[AW-1:0];

  charlcd_busy_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_busy (
    .clk(clk), .rst(rst),
    .start(acc && op != OP_STATUS),
    .long_sel(op == OP_CLEAR || op == OP_HOME),
    .tick(osc_tick), .busy(busy)
  );

  charlcd_addr_ctr #(.AW(AW)) u_ac (
    .clk(clk), .rst(rst),
    .zero(acc && (op == OP_CLEAR || op == OP_HOME)),
    .load(acc && (op == OP_DDADR || op == OP_CGADR)),
    .load_val(load_val), .load_cg(op == OP_CGADR),
    .step(acc && (op == OP_DWR || op == OP_DRD)),
    .inc(entry_inc), .ac(ac), .cg_sel(cg_sel)
  );

  assign ram_addr = ac;
  assign ram_cg   = cg_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_inc   <= 1'b1;
      entry_shift <= 1'b0;
      disp_on     <= 1'b0;
      cursor_on   <= 1'b0;
      blink_on    <= 1'b0;
      bus8        <= 1'b1;
      two_line    <= 1'b0;
      font_tall   <= 1'b0;
      contrast    <= '0;
      bus_rdata   <= '0;
      ram_we      <= 1'b0;
      ram_waddr   <= '0;
      ram_wcg     <= 1'b0;
      ram_wdata   <= '0;
      clear_stb   <= 1'b0;
      home_stb    <= 1'b0;
      shift_stb   <= 1'b0;
      shift_disp  <= 1'b0;
      shift_right <= 1'b0;
    end else begin
      ram_we    <= 1'b0;
      clear_stb <= 1'b0;
      home_stb  <= 1'b0;
      shift_stb <= 1'b0;
      if (acc) begin
        case (op)
          OP_CLEAR: clear_stb <= 1'b1;
          OP_HOME:  home_stb  <= 1'b1;
          OP_ENTRY: begin
            entry_inc   <= bus_wdata[1];
            entry_shift <= bus_wdata[0];
          end
          OP_DISP: begin
            disp_on   <= bus_wdata[2];
            cursor_on <= bus_wdata[1];
            blink_on  <= bus_wdata[0];
          end
          OP_SHIFT: begin
            shift_stb   <= 1'b1;
            shift_disp  <= bus_wdata[3];
            shift_right <= bus_wdata[2];
          end
          OP_FUNC: begin
            bus8      <= bus_wdata[4];
            two_line  <= bus_wdata[3];
            font_tall <= bus_wdata[2];
          end
          OP_STATUS: begin
            bus_rdata           <= '0;
            bus_rdata[DW-1]     <= busy;
            bus_rdata[AW-1:0]   <= ac;
          end
          OP_DWR: begin
            ram_we    <= 1'b1;
            ram_waddr <= ac;
            ram_wcg   <= cg_sel;
            ram_wdata <= bus_wdata;
          end
          OP_DRD:  bus_rdata <= ram_rdata;
          OP_KWR:  contrast  <= bus_wdata;
          OP_KRD:  bus_rdata <= contrast;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/charlcd_cmd_chk.sv
module charlcd_cmd_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_valid,
  input logic [1:0] bus_rs,
  input logic       bus_rw,
  input logic       osc_tick,
  input logic       busy,
  input logic       entry_inc,
  input logic       entry_shift,
  input logic       disp_on,
  input logic       cursor_on,
  input logic       blink_on,
  input logic       bus8,
  input logic       two_line,
  input logic       font_tall,
  input logic [7:0] contrast,
  input logic       ram_we,
  input logic       clear_stb,
  input logic       home_stb,
  input logic       shift_stb
);
  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !busy && bus_rs == 2'b11) |=> busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !osc_tick) |=> busy);

  // R7
  status_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !busy && bus_rs == 2'b10 && bus_rw) |=> !busy);

  // R8
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && busy && bus_rs == 2'b10 && !bus_rw) |=>
      $stable({entry_inc, entry_shift, disp_on, cursor_on, blink_on, bus8, two_line, font_tall}));

  // R11
  contrast_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && busy && bus_rs == 2'b00 && !bus_rw) |=> $stable(contrast));

  // R10
  ram_we_src_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(bus_valid && bus_rs == 2'b11 && !bus_rw && !busy));

  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clear_stb, home_stb, shift_stb}));
endmodule

bind charlcd_cmd_unit charlcd_cmd_chk u_chk (.*);

// File: tb/charlcd_cmd_unit_bench.sv
module charlcd_cmd_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0;
  logic [1:0] bus_rs = 2'b00;
  logic bus_rw = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic osc_tick = 1'b0;
  logic busy, entry_inc, entry_shift, disp_on, cursor_on, blink_on;
  logic bus8, two_line, font_tall;
  logic [7:0] contrast;
  logic [AW-1:0] ram_addr, ram_waddr;
  logic ram_cg, ram_we, ram_wcg;
  logic [7:0] ram_rdata, ram_wdata;
  logic clear_stb, home_stb, shift_stb, shift_disp, shift_right;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  charlcd_cmd_unit u_charlcd_cmd_unit (.*);

  assign ram_rdata = mem[{ram_cg, ram_addr}];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (ram_we) begin
      mem[{ram_wcg, ram_waddr}] <= ram_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_rs = rs; bus_rw = rw; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic status(output logic [7:0] v);
    access(2'b10, 1'b1, 8'h00);
    v = bus_rdata;
  endtask

  task automatic cmd_wait(input logic [7:0] d);
    access(2'b10, 1'b0, d);
    ticks(10);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 busy", busy, 0);
    chk("R1 cfg", {bus8, two_line, font_tall, disp_on, cursor_on, blink_on, entry_inc, entry_shift}, 8'b1000_0010);
    chk("R1 contrast", contrast, 0);
    status(v);
    chk("R1 R7 status", v, 8'h00);
  endtask

  task automatic t_func;
    access(2'b10, 1'b0, 8'h2C);
    chk("R4 func 4b/2l/tall", {bus8, two_line, font_tall}, 3'b011);
    chk("R6 busy set", busy, 1);
    ticks(9);
    chk("R6 busy before last tick", busy, 1);
    ticks(1);
    chk("R6 busy after last tick", busy, 0);
    cmd_wait(8'h30);
    chk("R4 func 8b/1l/short", {bus8, two_line, font_tall}, 3'b100);
  endtask

  task automatic t_disp;
    logic [7:0] v;
    cmd_wait(8'h0E);
    chk("R5 disp 110", {disp_on, cursor_on, blink_on}, 3'b110);
    access(2'b10, 1'b0, 8'h0D);
    access(2'b10, 1'b0, 8'h08);
    status(v);
    chk("R7 status while busy", v, 8'h80);
    ticks(10);
    chk("R8 R5 dropped while busy", {disp_on, cursor_on, blink_on}, 3'b101);
    status(v);
    chk("R7 status idle", v, 8'h00);
  endtask

  task automatic t_clear;
    access(2'b10, 1'b0, 8'h01);
    chk("R12 clear_stb", clear_stb, 1);
    ticks(409);
    chk("R6 long busy before last", busy, 1);
    ticks(1);
    chk("R6 long busy end", busy, 0);
  endtask

  task automatic t_data;
    logic [7:0] v;
    cmd_wait(8'h85);
    status(v);
    chk("R9 dd addr", v, 8'h05);
    access(2'b11, 1'b0, 8'h41);
    chk("R10 write pulse", {ram_we, ram_wcg, 1'b0, ram_waddr, ram_wdata}, {1'b1, 1'b0, 1'b0, 7'h05, 8'h41});
    ticks(10);
    status(v);
    chk("R10 inc", v, 8'h06);
    cmd_wait(8'h04);
    chk("R5 entry dec", {entry_inc, entry_shift}, 2'b00);
    access(2'b11, 1'b0, 8'h42); ticks(10);
    status(v);
    chk("R10 dec", v, 8'h05);
    access(2'b11, 1'b1, 8'h00);
    chk("R10 read", bus_rdata, 8'h41);
    ticks(10);
    status(v);
    chk("R10 read steps", v, 8'h04);
    cmd_wait(8'h80);
    access(2'b11, 1'b0, 8'h11); ticks(10);
    status(v);
    chk("R10 wrap down", v, 8'h7F);
    cmd_wait(8'h07);
    chk("R5 entry inc shift", {entry_inc, entry_shift}, 2'b11);
    access(2'b11, 1'b0, 8'h12); ticks(10);
    status(v);
    chk("R10 wrap up", v, 8'h00);
  endtask

  task automatic t_cg;
    logic [7:0] v;
    cmd_wait(8'h4A);
    status(v);
    chk("R9 cg addr", v, 8'h0A);
    chk("R9 cg select", ram_cg, 1);
    access(2'b11, 1'b0, 8'h1F);
    chk("R10 cg write", {ram_we, ram_wcg, ram_waddr}, {1'b1, 1'b1, 7'h0A});
    ticks(10);
    cmd_wait(8'h4A);
    access(2'b11, 1'b1, 8'h00);
    chk("R10 cg readback", bus_rdata, 8'h1F);
    ticks(10);
  endtask

  task automatic t_contrast;
    access(2'b00, 1'b0, 8'h5A);
    chk("R11 contrast write", contrast, 8'h5A);
    access(2'b00, 1'b0, 8'h33);
    ticks(10);
    chk("R8 contrast dropped", contrast, 8'h5A);
    access(2'b00, 1'b1, 8'h00);
    chk("R11 contrast read", bus_rdata, 8'h5A);
    ticks(10);
  endtask

  task automatic t_home_shift;
    logic [7:0] v;
    cmd_wait(8'h90);
    access(2'b10, 1'b0, 8'h02);
    chk("R12 home_stb", home_stb, 1);
    ticks(410);
    status(v);
    chk("R12 home addr", v, 8'h00);
    access(2'b10, 1'b0, 8'h1C);
    chk("R12 shift right disp", {shift_stb, shift_disp, shift_right}, 3'b111);
    ticks(10);
    access(2'b10, 1'b0, 8'h10);
    chk("R12 shift left cursor", {shift_stb, shift_disp, shift_right}, 3'b100);
    ticks(10);
  endtask

  task automatic t_ignored;
    access(2'b01, 1'b0, 8'hFF);
    chk("R2 rs01 dropped", busy, 0);
    access(2'b10, 1'b0, 8'h00);
    chk("R3 zero byte dropped", busy, 0);
    access(2'b10, 1'b0, 8'h3F);
    chk("R3 priority func", {bus8, two_line, font_tall, busy}, 4'b1111);
    ticks(10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_func();
    t_disp();
    t_clear();
    t_data();
    t_cg();
    t_contrast();
    t_home_shift();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule